// File: doc/BRIEF.md
# Nested Save-Frame Stack Controller

This block keeps the control record of a single enclave thread and manages a bounded stack of state-save frames in memory. Software first loads the record with the address of the frame array and the number of frames. Enclave threads then drive four kinds of events into the block: enter, resume, normal exit and asynchronous exit. An asynchronous exit pushes a frame. The block reports the memory address where the interrupted state must be stored, and it keeps the exit pointer that the thread supplied at its last enter or resume. A resume pops the most recent frame and reports the address to restore from. Nesting is allowed: a thread can enter again after an asynchronous exit and leave asynchronously again, up to the frame count.

Only one logical CPU may own the record at a time. A busy flag tracks that ownership. Any illegal transition is rejected with a one-cycle error pulse and a code, and the record is left unchanged. The block only computes addresses and control. Capturing register state and writing memory are left to the surrounding logic.

Top module: `frame_stack_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, busy_o is 0, frame_idx_o is 0, exit_ptr_o is 0, and save_vld_o, restore_vld_o and err_vld_o are 0.
- R2: An enter (evt_kind_i = 0) is accepted when the record is idle and frame_idx_o < total. It sets busy_o and loads exit_ptr_o from evt_ptr_i, and frame_idx_o does not change.
- R3: An asynchronous exit (evt_kind_i = 3) is accepted while the record is busy. It pulses save_vld_o for one cycle, with save_addr_o = base + frame_idx * FRAME_BYTES using the index before the push. It then increments frame_idx_o, clears busy_o, and leaves exit_ptr_o holding the exit target.
- R4: A resume (evt_kind_i = 1) is accepted when the record is idle and frame_idx_o > 0. It pulses restore_vld_o, with restore_addr_o = base + (frame_idx - 1) * FRAME_BYTES. It then decrements frame_idx_o, sets busy_o and loads exit_ptr_o from evt_ptr_i.
- R5: A normal exit (evt_kind_i = 2) is accepted while the record is busy. It clears busy_o, leaves frame_idx_o unchanged and raises no save or restore pulse.
- R6: An enter or resume while busy_o is 1 is rejected with err_code_o = 1, and the index, busy flag and exit pointer do not change.
- R7: An enter from an idle record whose frame_idx_o equals total is rejected with err_code_o = 2.
- R8: A resume from an idle record whose frame_idx_o is 0 is rejected with err_code_o = 3.
- R9: A normal or asynchronous exit while the record is idle is rejected with err_code_o = 4, and no save pulse is raised.
- R10: A configuration write (cfg_we_i with evt_vld_i low) on an idle record loads the base and total and clears frame_idx_o. On a busy record it is rejected with err_code_o = 5, and the old base stays in use.
- R11: Every result (the pulses, the error and the updated record) appears in the clock cycle after the event is sampled. Each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the frame array base and frame count |
| cfg_base_i | input | ADDR_W | Frame array base address |
| cfg_total_i | input | IDX_W | Number of frames available |
| evt_vld_i | input | 1 | Event strobe |
| evt_kind_i | input | 2 | 0 enter, 1 resume, 2 normal exit, 3 asynchronous exit |
| evt_ptr_i | input | ADDR_W | Exit pointer supplied with enter or resume |
| busy_o | output | 1 | Record owned by a logical CPU |
| frame_idx_o | output | IDX_W | Current frame index (stack depth) |
| exit_ptr_o | output | ADDR_W | Latched asynchronous exit target |
| save_vld_o | output | 1 | Frame save request pulse |
| save_addr_o | output | ADDR_W | Frame address to write |
| restore_vld_o | output | 1 | Frame restore request pulse |
| restore_addr_o | output | ADDR_W | Frame address to read back |
| err_vld_o | output | 1 | Rejected event or configuration pulse |
| err_code_o | output | 3 | 1 busy, 2 full, 3 empty, 4 idle, 5 config locked |

## Verification
Every result is registered once, so the pulses, the error code and the updated index, busy flag and exit pointer are all due on the first rising edge after the event is sampled. The bench applies each event at a falling edge and drops the strobe at the next falling edge. It reads all outputs at that second falling edge, which is half a period after the results settle. A further idle cycle after the last table row confirms that a pulse does not outlast its cycle.

// File: rtl/frame_stack_pkg.sv
package frame_stack_pkg;

  typedef enum logic [1:0] {
    EV_ENTER  = 2'd0,
    EV_RESUME = 2'd1,
    EV_EXIT   = 2'd2,
    EV_AEX    = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_BUSY     = 3'd1,
    ERR_FULL     = 3'd2,
    ERR_EMPTY    = 3'd3,
    ERR_IDLE     = 3'd4,
    ERR_CFG_LOCK = 3'd5
  } err_code_e;

  function automatic bit is_pow2(int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/frame_addr_gen.sv
module frame_addr_gen #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 4,
  parameter int FRAME_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  import frame_stack_pkg::*;

  localparam int SHIFT = $clog2(FRAME_BYTES);

  logic [ADDR_W-1:0] idx_ext;
  assign idx_ext = ADDR_W'(idx_i);

  generate
    if (is_pow2(FRAME_BYTES)) begin : g_shift
      assign addr_o = base_i + (idx_ext << SHIFT);
    end else begin : g_mult
      assign addr_o = base_i + idx_ext * ADDR_W'(FRAME_BYTES);
    end
  endgenerate

endmodule

// File: rtl/frame_event_check.sv
module frame_event_check #(
  parameter int IDX_W = 4
) (
  input  logic                           evt_vld_i,
  input  frame_stack_pkg::ev_kind_e      evt_kind_i,
  input  logic                           cfg_we_i,
  input  logic                           busy_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [IDX_W-1:0]               total_i,
  output logic                           acc_enter_o,
  output logic                           acc_resume_o,
  output logic                           acc_exit_o,
  output logic                           acc_aex_o,
  output logic                           acc_cfg_o,
  output logic                           err_vld_o,
  output frame_stack_pkg::err_code_e     err_code_o
);
  import frame_stack_pkg::*;

  always_comb begin
    acc_enter_o  = 1'b0;
    acc_resume_o = 1'b0;
    acc_exit_o   = 1'b0;
    acc_aex_o    = 1'b0;
    acc_cfg_o    = 1'b0;
    err_code_o   = ERR_NONE;
    if (evt_vld_i) begin
      // events take precedence over a coincident config write
      case (evt_kind_i)
        EV_ENTER: begin
          if (busy_i)                err_code_o = ERR_BUSY;
          else if (idx_i >= total_i) err_code_o = ERR_FULL;
          else                       acc_enter_o = 1'b1;
        end
        EV_RESUME: begin
          if (busy_i)                err_code_o = ERR_BUSY;
          else if (idx_i == '0)      err_code_o = ERR_EMPTY;
          else                       acc_resume_o = 1'b1;
        end
        EV_EXIT: begin
          if (!busy_i)               err_code_o = ERR_IDLE;
          else                       acc_exit_o = 1'b1;
        end
        EV_AEX: begin
          if (!busy_i)               err_code_o = ERR_IDLE;
          else                       acc_aex_o = 1'b1;
        end
        default: err_code_o = ERR_NONE;
      endcase
    end else if (cfg_we_i) begin
      if (busy_i) err_code_o = ERR_CFG_LOCK;
      else        acc_cfg_o  = 1'b1;
    end
    err_vld_o = (err_code_o != ERR_NONE);
  end

endmodule

// File: rtl/frame_record.sv
module frame_record #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_enter_i,
  input  logic              acc_resume_i,
  input  logic              acc_exit_i,
  input  logic              acc_aex_i,
  input  logic              acc_cfg_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [IDX_W-1:0]  cfg_total_i,
  input  logic [ADDR_W-1:0] evt_ptr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]  total_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] xptr_o
);

  logic [ADDR_W-1:0] base_q, xptr_q;
  logic [IDX_W-1:0]  total_q, idx_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      total_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      xptr_q  <= '0;
    end else begin
      if (acc_cfg_i) begin
        base_q  <= cfg_base_i;
        total_q <= cfg_total_i;
        idx_q   <= '0;
      end
      if (acc_enter_i) begin
        busy_q <= 1'b1;
        xptr_q <= evt_ptr_i;
      end
      if (acc_resume_i) begin
        busy_q <= 1'b1;
        xptr_q <= evt_ptr_i;
        idx_q  <= idx_q - IDX_W'(1);
      end
      if (acc_exit_i) busy_q <= 1'b0;
      if (acc_aex_i) begin
        busy_q <= 1'b0;
        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  assign base_o  = base_q;
  assign total_o = total_q;
  assign idx_o   = idx_q;
  assign busy_o  = busy_q;
  assign xptr_o  = xptr_q;

  assert_idx_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= total_q);

  assert_exit_keeps_idx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_exit_i |=> ($stable(idx_q) && !busy_q));

  assert_owner_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_enter_i || acc_resume_i) |-> !busy_q);

endmodule

// File: rtl/frame_stack_ctrl.sv
module frame_stack_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 4,
  parameter int FRAME_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [IDX_W-1:0]  cfg_total_i,
  input  logic              evt_vld_i,
  input  logic [1:0]        evt_kind_i,
  input  logic [ADDR_W-1:0] evt_ptr_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  frame_idx_o,
  output logic [ADDR_W-1:0] exit_ptr_o,
  output logic              save_vld_o,
  output logic [ADDR_W-1:0] save_addr_o,
  output logic              restore_vld_o,
  output logic [ADDR_W-1:0] restore_addr_o,
  output logic              err_vld_o,
  output logic [2:0]        err_code_o
);
  import frame_stack_pkg::*;

  logic acc_enter, acc_resume, acc_exit, acc_aex, acc_cfg, err_vld;
  err_code_e err_code;
  logic [ADDR_W-1:0] base, xptr, push_addr, pop_addr;
  logic [IDX_W-1:0]  total, idx, idx_dec;
  logic              busy;

  frame_event_check #(.IDX_W(IDX_W)) i_check (
    .evt_vld_i   (evt_vld_i),
    .evt_kind_i  (ev_kind_e'(evt_kind_i)),
    .cfg_we_i    (cfg_we_i),
    .busy_i      (busy),
    .idx_i       (idx),
    .total_i     (total),
    .acc_enter_o (acc_enter),
    .acc_resume_o(acc_resume),
    .acc_exit_o  (acc_exit),
    .acc_aex_o   (acc_aex),
    .acc_cfg_o   (acc_cfg),
    .err_vld_o   (err_vld),
    .err_code_o  (err_code)
  );

  frame_record #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_record (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_enter_i (acc_enter),
    .acc_resume_i(acc_resume),
    .acc_exit_i  (acc_exit),
    .acc_aex_i   (acc_aex),
    .acc_cfg_i   (acc_cfg),
    .cfg_base_i  (cfg_base_i),
    .cfg_total_i (cfg_total_i),
    .evt_ptr_i   (evt_ptr_i),
    .base_o      (base),
    .total_o     (total),
    .idx_o       (idx),
    .busy_o      (busy),
    .xptr_o      (xptr)
  );

  assign idx_dec = idx - IDX_W'(1);

  frame_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .FRAME_BYTES(FRAME_BYTES)) i_push_addr (
    .base_i(base),
    .idx_i (idx),
    .addr_o(push_addr)
  );

  frame_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .FRAME_BYTES(FRAME_BYTES)) i_pop_addr (
    .base_i(base),
    .idx_i (idx_dec),
    .addr_o(pop_addr)
  );

  logic              save_vld_q, restore_vld_q, err_vld_q;
  logic [ADDR_W-1:0] save_addr_q, restore_addr_q;
  logic [2:0]        err_code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      save_vld_q     <= 1'b0;
      save_addr_q    <= '0;
      restore_vld_q  <= 1'b0;
      restore_addr_q <= '0;
      err_vld_q      <= 1'b0;
      err_code_q     <= '0;
    end else begin
      save_vld_q    <= acc_aex;
      restore_vld_q <= acc_resume;
      err_vld_q     <= err_vld;
      err_code_q    <= err_code;
      if (acc_aex)    save_addr_q    <= push_addr;
      if (acc_resume) restore_addr_q <= pop_addr;
    end
  end

  assign busy_o         = busy;
  assign frame_idx_o    = idx;
  assign exit_ptr_o     = xptr;
  assign save_vld_o     = save_vld_q;
  assign save_addr_o    = save_addr_q;
  assign restore_vld_o  = restore_vld_q;
  assign restore_addr_o = restore_addr_q;
  assign err_vld_o      = err_vld_q;
  assign err_code_o     = err_code_q;

  assert_save_releases_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_vld_q |-> (!busy && idx != '0));

  assert_pop_owns_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_vld_q |-> (busy && idx == $past(idx) - IDX_W'(1)));

  assert_err_keeps_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_q |-> (idx == $past(idx) && busy == $past(busy) && xptr == $past(xptr)));

  assert_pulse_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({save_vld_q, restore_vld_q, err_vld_q}));

  assert_idle_no_save_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_i && evt_kind_i == 2'd3 && !busy) |=> !save_vld_q);

endmodule

// File: tb/test_frame_stack_ctrl.sv
`timescale 1ns/1ps
module test_frame_stack_ctrl;

  localparam int AW = 32;
  localparam int IW = 4;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] PA = 32'h0000_A000, PB = 32'h0000_B000, PC = 32'h0000_C000,
                          PD = 32'h0000_D000, PE = 32'h0000_E000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 1'b0, evt_vld_i = 1'b0;
  logic [AW-1:0] cfg_base_i = '0, evt_ptr_i = '0;
  logic [IW-1:0] cfg_total_i = '0;
  logic [1:0] evt_kind_i = '0;
  logic busy_o, save_vld_o, restore_vld_o, err_vld_o;
  logic [IW-1:0] frame_idx_o;
  logic [AW-1:0] exit_ptr_o, save_addr_o, restore_addr_o;
  logic [2:0] err_code_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  frame_stack_ctrl i_frame_stack_ctrl (.*);

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] ptr;
    logic [2:0]  err;
    logic        sv;
    logic [31:0] sa;
    logic        rv;
    logic [31:0] ra;
    logic [3:0]  idx;
    logic        busy;
    logic [31:0] xp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 32'h0, 3'd4, 1'b0, 32'h0, 1'b0, 32'h0, 4'd0, 1'b0, 32'h0},
    '{2'd3, 32'h0, 3'd4, 1'b0, 32'h0, 1'b0, 32'h0, 4'd0, 1'b0, 32'h0},
    '{2'd1, 32'h0, 3'd3, 1'b0, 32'h0, 1'b0, 32'h0, 4'd0, 1'b0, 32'h0},
    '{2'd0, PA,    3'd0, 1'b0, 32'h0, 1'b0, 32'h0, 4'd0, 1'b1, PA},
    '{2'd0, PB,    3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 4'd0, 1'b1, PA},
    '{2'd3, 32'h0, 3'd0, 1'b1, BASE,  1'b0, 32'h0, 4'd1, 1'b0, PA},
    '{2'd0, PB,    3'd0, 1'b0, 32'h0, 1'b0, 32'h0, 4'd1, 1'b1, PB},
    '{2'd3, 32'h0, 3'd0, 1'b1, BASE + 32'h1000, 1'b0, 32'h0, 4'd2, 1'b0, PB},
    '{2'd0, PC,    3'd0, 1'b0, 32'h0, 1'b0, 32'h0, 4'd2, 1'b1, PC},
    '{2'd3, 32'h0, 3'd0, 1'b1, BASE + 32'h2000, 1'b0, 32'h0, 4'd3, 1'b0, PC},
    '{2'd0, PD,    3'd2, 1'b0, 32'h0, 1'b0, 32'h0, 4'd3, 1'b0, PC},
    '{2'd1, PD,    3'd0, 1'b0, 32'h0, 1'b1, BASE + 32'h2000, 4'd2, 1'b1, PD},
    '{2'd1, PE,    3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 4'd2, 1'b1, PD},
    '{2'd2, 32'h0, 3'd0, 1'b0, 32'h0, 1'b0, 32'h0, 4'd2, 1'b0, PD},
    '{2'd1, PE,    3'd0, 1'b0, 32'h0, 1'b1, BASE + 32'h1000, 4'd1, 1'b1, PE},
    '{2'd3, 32'h0, 3'd0, 1'b1, BASE + 32'h1000, 1'b0, 32'h0, 4'd2, 1'b0, PE}
  };

  function automatic string req_of(logic [1:0] kind, logic [2:0] err);
    case (err)
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      3'd5: return "R10";
      default: case (kind)
        2'd0: return "R2";
        2'd1: return "R4";
        2'd2: return "R5";
        default: return "R3";
      endcase
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic evt(logic [1:0] kind, logic [31:0] ptr);
    evt_kind_i = kind; evt_ptr_i = ptr; evt_vld_i = 1'b1;
    @(negedge clk_i);
    evt_vld_i = 1'b0;
  endtask

  task automatic cfg(logic [31:0] base, logic [3:0] total);
    cfg_base_i = base; cfg_total_i = total; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic check_idle_reset(string req);
    check(req, "busy", 32'(busy_o), 0);
    check(req, "idx", 32'(frame_idx_o), 0);
    check(req, "xptr", exit_ptr_o, 0);
    check(req, "pulses", 32'({save_vld_o, restore_vld_o, err_vld_o}), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_idle_reset("R1");            // R1 during reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle_reset("R1");            // R1 after release

    cfg(BASE, 4'd3);                   // R10 idle load
    check("R10", "err", 32'(err_vld_o), 0);
    check("R10", "idx", 32'(frame_idx_o), 0);

    for (int i = 0; i < NV; i++) begin
      string r;
      r = req_of(VECS[i].kind, VECS[i].err);
      evt(VECS[i].kind, VECS[i].ptr);
      check(r, "err_vld", 32'(err_vld_o), 32'(VECS[i].err != 3'd0));
      check(r, "err_code", 32'(err_code_o), 32'(VECS[i].err));
      check(r, "save_vld", 32'(save_vld_o), 32'(VECS[i].sv));
      if (VECS[i].sv) check(r, "save_addr", save_addr_o, VECS[i].sa);
      check(r, "restore_vld", 32'(restore_vld_o), 32'(VECS[i].rv));
      if (VECS[i].rv) check(r, "restore_addr", restore_addr_o, VECS[i].ra);
      check(r, "idx", 32'(frame_idx_o), 32'(VECS[i].idx));
      check(r, "busy", 32'(busy_o), 32'(VECS[i].busy));
      check(r, "xptr", exit_ptr_o, VECS[i].xp);
    end

    @(negedge clk_i);                  // R11 pulses last one cycle
    check("R11", "save_vld after idle cycle", 32'(save_vld_o), 0);
    check("R11", "idx held", 32'(frame_idx_o), 2);

    // R10 config while busy is rejected and old base stays
    evt(2'd0, 32'h0000_F000);
    check("R2", "busy", 32'(busy_o), 1);
    cfg(32'h0020_0000, 4'd5);
    check("R10", "err_code", 32'(err_code_o), 5);
    check("R10", "idx kept", 32'(frame_idx_o), 2);
    evt(2'd3, 32'h0);
    check("R10", "save_addr old base", save_addr_o, BASE + 32'h2000);
    check("R3", "idx", 32'(frame_idx_o), 3);

    // R10 reload while idle, then R7 at a total of 1
    cfg(32'h0020_0000, 4'd1);
    check("R10", "err", 32'(err_vld_o), 0);
    check("R10", "idx cleared", 32'(frame_idx_o), 0);
    evt(2'd0, 32'h0000_1230);
    evt(2'd3, 32'h0);
    check("R3", "save_addr new base", save_addr_o, 32'h0020_0000);
    check("R3", "xptr", exit_ptr_o, 32'h0000_1230);
    evt(2'd0, 32'h0000_4560);
    check("R7", "err_code", 32'(err_code_o), 2);
    check("R7", "busy", 32'(busy_o), 0);

    // R1 reset in the middle of a nested run
    evt(2'd1, 32'h0000_7770);
    check("R4", "restore_addr", restore_addr_o, 32'h0020_0000);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_idle_reset("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule